// File: doc/BRIEF.md
# Paired-Execution Result Checker

This block sits beside the functional units of a wide-issue data path in which every operation is executed twice, on two different functional units, possibly in different cycles. Each issue lane carries three extra control fields besides the usual opcode and destination: a mode bit, an index into a small scratch register bank, and the number of the partner lane that runs the same operation. The first copy of an operation runs in store mode. It parks its result in the scratch bank. The second copy runs in check mode. It reads the parked value back, compares it with its own result and then either releases the write-back to the architectural register file or holds it.

A vector of known-bad operators (one bit per operator per lane) is an input. On a mismatch the block uses this vector to decide what happens. If neither operator involved is marked bad, the mismatch is a new fault: a one-cycle error pulse, carrying the opcode, goes to an external voting controller and the write-back is withheld. If one side is already marked bad, the good side's value is written back without delay and no error is raised. The voting controller can also hold off any lane's write-back through a per-lane disable input.

Top module: `pair_check_cluster`

## Requirements
- R1: Synchronous active-low reset clears every output to 0 and every scratch-bank entry to 0.
- R2: A valid operation with mode 0 writes `fu_result` into scratch entry `op_ref_reg` at the clock edge. It raises neither `rf_we` nor `err_new`.
- R3: A mode-1 operation compares against the scratch entry as it stood before the current edge. A store to the same entry in the same cycle is not visible to it.
- R4: A valid mode-1 operation is a match when its result equals the scratch value and neither operator is marked bad. On a match, one cycle after issue `rf_we` is 1, `rf_wdata` is the lane's own result and `rf_dst` is `op_dst`.
- R5: On a mode-1 mismatch with neither operator marked bad, `err_new` is 1 for exactly the next cycle, `err_opc` holds the opcode and `rf_we` stays 0.
- R6: Fault bit `lane*NUM_OPS + opcode` marks the checking lane's operator as bad. If that bit is set, the scratch value is written back and no error is raised, whatever the compare gives.
- R7: Fault bit `op_ref_fu*NUM_OPS + opcode` marks the partner's operator as bad. If only that bit is set, the lane's own result is written back and no error is raised. When both bits are set, R6 applies.
- R8: A write-back decided by a known fault appears one cycle after issue, the same latency as a fault-free match.
- R9: `vote_wdis` high in the issue cycle forces `rf_we` to 0 for that lane's operation.
- R10: When several lanes store to the same scratch entry in one cycle, the value from the highest-numbered lane is kept.
- R11: A lane with `op_valid` low changes no scratch entry and raises neither `rf_we` nor `err_new` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | NUM_FU | Per-lane operation present |
| op_mode | input | NUM_FU | 0 = store result, 1 = check against stored value |
| op_code | input | NUM_FU x OP_W | Operator number of each lane's operation |
| op_ref_reg | input | NUM_FU x IDX_W | Scratch-bank entry for store or check |
| op_ref_fu | input | NUM_FU x FU_W | Lane that runs the partner copy |
| op_dst | input | NUM_FU x DST_W | Architectural destination register |
| fu_result | input | NUM_FU x DATA_W | Result of each functional unit |
| fault_vec | input | NUM_FU*NUM_OPS | Known-bad operator map, bit lane*NUM_OPS+op |
| vote_wdis | input | NUM_FU | Write-back hold from voting controller |
| rf_we | output | NUM_FU | Architectural write enable |
| rf_wdata | output | NUM_FU x DATA_W | Architectural write data |
| rf_dst | output | NUM_FU x DST_W | Architectural write address |
| err_new | output | NUM_FU | New-fault pulse to voting controller |
| err_opc | output | NUM_FU x OP_W | Opcode of the last valid operation per lane |

## Verification
A corrupted scratch entry does not show at the ports when it is stored. It shows only when a later check-mode operation reads that entry. The first sign is then a false `err_new` pulse or a wrong `rf_wdata`, one cycle after that check issues. A wrong choice of fault bit shows at once, on the first check that touches the marked operator: the wrong value is written back, or an error fires that should have been absorbed. For that reason the stimulus keeps the gap between store and check short and puts a check on every stored entry, so that stale or misrouted state surfaces within a few cycles.

// File: rtl/pair_check_pkg.sv
// Package: shared verdict type for the paired-execution checker.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pair_check_pkg;

    // Outcome of one lane's operation in the issue cycle
    typedef enum logic [1:0] {
        VERDICT_NONE     = 2'd0,
        VERDICT_OWN      = 2'd1,
        VERDICT_PARTNER  = 2'd2,
        VERDICT_NEW_ERR  = 2'd3
    } verdict_t;

endpackage

// File: rtl/pair_scratch_bank.sv
// Scratch register bank holding the first-copy results.
// One write port and one asynchronous read port per lane. Concurrent
// writes to one entry resolve to the highest lane. DEPTH is assumed
// to be a power of two.
module pair_scratch_bank #(
    parameter int NUM_FU = 4,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_FU-1:0]              wr_en,
    input  logic [NUM_FU-1:0][IDX_W-1:0]   wr_idx,
    input  logic [NUM_FU-1:0][DATA_W-1:0]  wr_data,
    input  logic [NUM_FU-1:0][IDX_W-1:0]   rd_idx,
    output logic [NUM_FU-1:0][DATA_W-1:0]  rd_data
);

    logic [DEPTH-1:0][DATA_W-1:0] mem;

    // Store ports, later lanes overwrite earlier ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else begin
            for (int l = 0; l < NUM_FU; l++) begin
                if (wr_en[l]) mem[wr_idx[l]] <= wr_data[l];
            end
        end
    end

    // Read ports see the contents before this edge's stores
    always_comb begin
        for (int l = 0; l < NUM_FU; l++) rd_data[l] = mem[rd_idx[l]];
    end

    // R10
    top_lane_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[NUM_FU-1] |=> mem[$past(wr_idx[NUM_FU-1])] == $past(wr_data[NUM_FU-1]));

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> mem[0] == '0);

endmodule

// File: rtl/pair_lane_check.sv
// Per-lane decision logic. It classifies the lane's operation from
// the mode bit, the compare against the scratch value and the two
// known-bad operator bits, then registers the write-back and error
// outputs. Assumes NUM_OPS is a power of two and the partner number
// is below NUM_FU.
module pair_lane_check
    import pair_check_pkg::*;
#(
    parameter int LANE    = 0,
    parameter int NUM_FU  = 4,
    parameter int NUM_OPS = 4,
    parameter int DATA_W  = 16,
    parameter int DST_W   = 4,
    localparam int FU_W   = $clog2(NUM_FU),
    localparam int OP_W   = $clog2(NUM_OPS),
    localparam int FV_W   = NUM_FU * NUM_OPS,
    localparam int FVI_W  = $clog2(FV_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              mode,
    input  logic [OP_W-1:0]   opc,
    input  logic [FU_W-1:0]   ref_fu,
    input  logic [DST_W-1:0]  dst,
    input  logic [DATA_W-1:0] result,
    input  logic [DATA_W-1:0] ref_val,
    input  logic [FV_W-1:0]   fault_vec,
    input  logic              wdis,
    output logic              store_en,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [DST_W-1:0]  rf_dst,
    output logic              err_new,
    output logic [OP_W-1:0]   err_opc
);

    logic [FVI_W-1:0] own_idx;
    logic [FVI_W-1:0] ref_idx;
    logic             own_bad;
    logic             ref_bad;
    verdict_t         verdict;

    // Locate the two operator fault bits
    always_comb begin
        own_idx = FVI_W'(LANE * NUM_OPS) + FVI_W'(opc);
        ref_idx = FVI_W'(ref_fu) * FVI_W'(NUM_OPS) + FVI_W'(opc);
        own_bad = fault_vec[own_idx];
        ref_bad = fault_vec[ref_idx];
    end

    // Classify the operation; own-operator fault has priority
    always_comb begin
        verdict = VERDICT_NONE;
        if (valid && mode) begin
            if (own_bad)                verdict = VERDICT_PARTNER;
            else if (ref_bad)           verdict = VERDICT_OWN;
            else if (result == ref_val) verdict = VERDICT_OWN;
            else                        verdict = VERDICT_NEW_ERR;
        end
    end

    assign store_en = valid && !mode;

    // Register write-back and error outputs one cycle after issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_we    <= 1'b0;
            rf_wdata <= '0;
            rf_dst   <= '0;
            err_new  <= 1'b0;
            err_opc  <= '0;
        end else begin
            rf_we    <= (verdict == VERDICT_OWN || verdict == VERDICT_PARTNER) && !wdis;
            rf_wdata <= (verdict == VERDICT_PARTNER) ? ref_val : result;
            rf_dst   <= dst;
            err_new  <= (verdict == VERDICT_NEW_ERR);
            if (valid) err_opc <= opc;
        end
    end

    // R5
    err_blocks_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_new && rf_we));

    // R2
    store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !mode) |=> (!rf_we && !err_new));

    // R9
    wdis_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdis |=> !rf_we);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (!rf_we && !err_new));

    // R6
    own_bad_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode && own_bad && !wdis) |=> (rf_we && rf_wdata == $past(ref_val)));

    // R7
    partner_bad_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode && !own_bad && ref_bad && !wdis) |=> (rf_we && rf_wdata == $past(result)));

endmodule

// File: rtl/pair_check_cluster.sv
// Top: one decision lane per functional unit sharing one scratch bank.
// Store-mode lanes write the bank; check-mode lanes read it by the
// same index. Assumes the store copy issues in an earlier cycle than
// its check copy.
module pair_check_cluster #(
    parameter int NUM_FU    = 4,
    parameter int NUM_OPS   = 4,
    parameter int DATA_W    = 16,
    parameter int TRF_DEPTH = 8,
    parameter int NUM_REGS  = 16,
    localparam int FU_W     = $clog2(NUM_FU),
    localparam int OP_W     = $clog2(NUM_OPS),
    localparam int IDX_W    = $clog2(TRF_DEPTH),
    localparam int DST_W    = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_FU-1:0]              op_valid,
    input  logic [NUM_FU-1:0]              op_mode,
    input  logic [NUM_FU-1:0][OP_W-1:0]    op_code,
    input  logic [NUM_FU-1:0][IDX_W-1:0]   op_ref_reg,
    input  logic [NUM_FU-1:0][FU_W-1:0]    op_ref_fu,
    input  logic [NUM_FU-1:0][DST_W-1:0]   op_dst,
    input  logic [NUM_FU-1:0][DATA_W-1:0]  fu_result,
    input  logic [NUM_FU*NUM_OPS-1:0]      fault_vec,
    input  logic [NUM_FU-1:0]              vote_wdis,
    output logic [NUM_FU-1:0]              rf_we,
    output logic [NUM_FU-1:0][DATA_W-1:0]  rf_wdata,
    output logic [NUM_FU-1:0][DST_W-1:0]   rf_dst,
    output logic [NUM_FU-1:0]              err_new,
    output logic [NUM_FU-1:0][OP_W-1:0]    err_opc
);

    logic [NUM_FU-1:0]             store_en;
    logic [NUM_FU-1:0][DATA_W-1:0] ref_val;

    pair_scratch_bank #(
        .NUM_FU (NUM_FU),
        .DATA_W (DATA_W),
        .DEPTH  (TRF_DEPTH)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_en),
        .wr_idx  (op_ref_reg),
        .wr_data (fu_result),
        .rd_idx  (op_ref_reg),
        .rd_data (ref_val)
    );

    for (genvar g = 0; g < NUM_FU; g++) begin : g_lane
        pair_lane_check #(
            .LANE    (g),
            .NUM_FU  (NUM_FU),
            .NUM_OPS (NUM_OPS),
            .DATA_W  (DATA_W),
            .DST_W   (DST_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .valid     (op_valid[g]),
            .mode      (op_mode[g]),
            .opc       (op_code[g]),
            .ref_fu    (op_ref_fu[g]),
            .dst       (op_dst[g]),
            .result    (fu_result[g]),
            .ref_val   (ref_val[g]),
            .fault_vec (fault_vec),
            .wdis      (vote_wdis[g]),
            .store_en  (store_en[g]),
            .rf_we     (rf_we[g]),
            .rf_wdata  (rf_wdata[g]),
            .rf_dst    (rf_dst[g]),
            .err_new   (err_new[g]),
            .err_opc   (err_opc[g])
        );
    end

endmodule

// File: tb/tb_pair_check_cluster.sv
`timescale 1ns/1ps
module tb_pair_check_cluster;
    localparam int NF = 4;
    localparam int NO = 4;
    localparam int DW = 16;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NF-1:0] op_valid, op_mode, vote_wdis;
    logic [NF-1:0][1:0] op_code, op_ref_fu;
    logic [NF-1:0][2:0] op_ref_reg;
    logic [NF-1:0][3:0] op_dst;
    logic [NF-1:0][DW-1:0] fu_result;
    logic [NF*NO-1:0] fault_vec;
    logic [NF-1:0] rf_we, err_new;
    logic [NF-1:0][DW-1:0] rf_wdata;
    logic [NF-1:0][3:0] rf_dst;
    logic [NF-1:0][1:0] err_opc;

    always #2 clk = ~clk;

    pair_check_cluster dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
        .op_code(op_code), .op_ref_reg(op_ref_reg), .op_ref_fu(op_ref_fu),
        .op_dst(op_dst), .fu_result(fu_result), .fault_vec(fault_vec),
        .vote_wdis(vote_wdis), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .rf_dst(rf_dst), .err_new(err_new), .err_opc(err_opc)
    );

    int tests = 0;
    int fails = 0;
    int trf_m [DEPTH];
    bit e_we [NF];
    bit e_err [NF];
    int e_data [NF];
    int e_dst [NF];
    int e_opc [NF];
    string e_tag [NF];

    task automatic check_val(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        op_valid = '0; op_mode = '0; vote_wdis = '0;
        op_code = '0; op_ref_reg = '0; op_ref_fu = '0; op_dst = '0; fu_result = '0;
    endtask

    task automatic put(int l, bit m, int opc, int rr, int rf, int dst, int res);
        op_valid[l] = 1'b1; op_mode[l] = m; op_code[l] = 2'(opc);
        op_ref_reg[l] = 3'(rr); op_ref_fu[l] = 2'(rf); op_dst[l] = 4'(dst);
        fu_result[l] = DW'(res);
    endtask

    // Behavioural model: predict, advance one clock, compare at negedge
    task automatic cycle();
        for (int l = 0; l < NF; l++) begin
            e_we[l] = 0; e_err[l] = 0; e_data[l] = 0; e_dst[l] = op_dst[l];
            e_tag[l] = "R11";
            if (op_valid[l]) begin
                e_opc[l] = op_code[l];
                if (!op_mode[l]) e_tag[l] = "R2";
                else begin
                    int rv = trf_m[op_ref_reg[l]];
                    bit ob = fault_vec[l*NO + op_code[l]];
                    bit rb = fault_vec[op_ref_fu[l]*NO + op_code[l]];
                    if (ob) begin e_we[l] = 1; e_data[l] = rv; e_tag[l] = "R6"; end
                    else if (rb) begin e_we[l] = 1; e_data[l] = fu_result[l]; e_tag[l] = "R7"; end
                    else if (rv == int'(fu_result[l])) begin e_we[l] = 1; e_data[l] = fu_result[l]; e_tag[l] = "R4"; end
                    else begin e_err[l] = 1; e_tag[l] = "R5"; end
                    if (vote_wdis[l] && e_we[l]) begin e_we[l] = 0; e_tag[l] = "R9"; end
                end
            end
        end
        for (int l = 0; l < NF; l++)
            if (op_valid[l] && !op_mode[l]) trf_m[op_ref_reg[l]] = fu_result[l];
        @(posedge clk);
        @(negedge clk);
        for (int l = 0; l < NF; l++) begin
            check_val(e_tag[l], rf_we[l], e_we[l]);
            check_val(e_tag[l], err_new[l], e_err[l]);
            if (e_we[l]) begin
                check_val(e_tag[l], rf_wdata[l], e_data[l]);
                check_val(e_tag[l], rf_dst[l], e_dst[l]);
            end
            if (e_err[l]) check_val(e_tag[l], err_opc[l], e_opc[l]);
        end
        idle();
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle();
        fault_vec = '0;
        for (int i = 0; i < DEPTH; i++) trf_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs cleared
        for (int l = 0; l < NF; l++) begin
            check_val("R1", rf_we[l], 0);
            check_val("R1", err_new[l], 0);
            check_val("R1", rf_wdata[l], 0);
        end
        // R1: scratch entry 5 reads zero
        put(2, 1, 0, 5, 0, 7, 0); cycle();
        check_val("R1", rf_we[2], 1);

        // R2 then R4: store on lane 1, check on lane 2 two cycles later
        put(1, 0, 1, 3, 2, 4, 'h1234); cycle();
        cycle();
        put(2, 1, 1, 3, 1, 4, 'h1234); cycle();
        check_val("R4", rf_wdata[2], 'h1234);

        // R3: same-cycle store is invisible; following check matches
        put(0, 0, 2, 4, 1, 0, 'hAAAA); put(1, 1, 2, 4, 0, 2, 'hAAAA); cycle();
        check_val("R3", err_new[1], 1);
        put(1, 1, 2, 4, 0, 2, 'hAAAA); cycle();
        check_val("R3", rf_we[1], 1);

        // R5: lane 3 stuck at FFFF
        put(0, 0, 3, 1, 3, 0, 'h0042); cycle();
        put(3, 1, 3, 1, 0, 9, 'hFFFF); cycle();
        check_val("R5", err_opc[3], 3);

        // R6 and R8: lane 2 operator 1 known bad, stuck result
        fault_vec = '0; fault_vec[2*NO+1] = 1'b1;
        put(0, 0, 1, 2, 2, 0, 'h0777); cycle();
        put(2, 1, 1, 2, 0, 6, 'hFFFF); cycle();
        check_val("R8", rf_we[2], 1);
        check_val("R6", rf_wdata[2], 'h0777);

        // R7: partner lane 0 operator 2 known bad, stored value stuck
        fault_vec = '0; fault_vec[0*NO+2] = 1'b1;
        put(0, 0, 2, 7, 3, 0, 'h0000); cycle();
        put(3, 1, 2, 7, 0, 5, 'h5151); cycle();
        check_val("R7", rf_wdata[3], 'h5151);
        // R7: both bits set, own-bad rule wins
        fault_vec[3*NO+2] = 1'b1;
        put(3, 1, 2, 7, 0, 5, 'h5151); cycle();
        check_val("R7", rf_wdata[3], 'h0000);
        fault_vec = '0;

        // R9: write-back held by voting controller
        put(1, 0, 0, 0, 2, 0, 'h0BEE); cycle();
        put(2, 1, 0, 0, 1, 3, 'h0BEE); vote_wdis[2] = 1'b1; cycle();
        check_val("R9", rf_we[2], 0);

        // R10: lanes 1 and 3 collide on entry 6
        put(1, 0, 0, 6, 0, 0, 'h1111); put(3, 0, 0, 6, 0, 0, 'h3333); cycle();
        put(0, 1, 0, 6, 3, 8, 'h3333); cycle();
        check_val("R10", rf_we[0], 1);
        check_val("R10", rf_wdata[0], 'h3333);

        // R11: invalid lanes with busy fields change nothing
        op_mode = '1; fu_result = '1; op_ref_reg = '0; cycle();
        put(0, 1, 0, 6, 3, 1, 'h3333); cycle();
        check_val("R11", rf_we[0], 1);

        // Mixed random traffic checked every cycle by the model
        for (int n = 0; n < 400; n++) begin
            fault_vec = ($urandom_range(0, 3) == 0) ? (NF*NO)'($urandom) : '0;
            for (int l = 0; l < NF; l++) begin
                if ($urandom_range(0, 3) != 0) begin
                    int rr = $urandom_range(0, DEPTH-1);
                    bit m = 1'($urandom);
                    int res = ($urandom_range(0, 2) != 0 && m) ? trf_m[rr] : int'(16'($urandom));
                    put(l, m, $urandom_range(0, NO-1), rr, $urandom_range(0, NF-1),
                        $urandom_range(0, 15), res);
                    vote_wdis[l] = ($urandom_range(0, 7) == 0);
                end
            end
            cycle();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule